// File: doc/BRIEF.md
# Per-CPU Interrupt Interface

This block stands between an interrupt distributor and a single processor. Each cycle it sees two candidate sources: the best pending interrupt that the distributor forwards, and an interrupt raised locally for this processor alone. It picks the more urgent of the two. It then compares that candidate's priority with a programmable threshold and with the priority of the work the processor is already serving, and drives a registered interrupt request line to the processor.

Software uses four registers on a 32-bit bus with word addresses. It reads an acknowledge register to claim the interrupt. The claim pulses a take strobe back to the source that owned it. It also pushes the old running priority onto a small nesting stack and raises the running priority to the claimed interrupt's level. Only an interrupt more urgent than that level can then preempt. When the handler finishes, it writes the interrupt ID to a completion register. The block pops the stack and restores the earlier running priority. A completion write with the wrong ID leaves everything unchanged.

Top module: `pcpu_irq_if`

## Requirements
- R1: After reset the request output is low, control reads 0, the mask reads 0, the running priority (word 4) reads 0xFF and an acknowledge read returns 1023.
- R2: Bit 0 of the control register (word 0) enables signalling. While it is 0 the request output stays low and an acknowledge read returns 1023.
- R3: A lower numeric priority is more urgent. A candidate is signalled only when its priority is strictly below the mask held in bits 7:0 of word 1. A priority equal to the mask is not signalled.
- R4: A candidate is signalled only when its priority is strictly below the running priority, which reads in bits 7:0 of word 4 and is 0xFF when nothing is active.
- R5: When both sources are valid, the lower priority value wins. On a tie the local source wins. The claim raises only the winner's take strobe: dist_take for the distributor, loc_take for the local source.
- R6: A read of word 2 returns the qualifying winner's ID in bits 9:0 with all upper bits zero. In the same cycle it pulses the winner's take strobe with take_id equal to that ID. From the next cycle the running priority equals the claimed priority.
- R7: The request output is registered. It shows the qualification of the previous cycle, and it is low in the cycle after a successful acknowledge.
- R8: Writing to word 3 an ID in bits 9:0 that equals the most recently acknowledged active ID pops it and restores the running priority in force before that acknowledge.
- R9: A write to word 3 whose ID differs from the most recently acknowledged active ID, or made while nothing is active, changes neither the running priority nor the stack.
- R10: The nesting stack holds 4 entries. While it is full, the request output is low, an acknowledge read returns 1023 and no take strobe pulses.
- R11: Control reads back only bit 0 and the mask reads back only bits 7:0 of what was written. Addresses 5 to 7 read 0, and the bus output is 0 when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_valid | input | 1 | Distributor candidate present |
| dist_id | input | 10 | Distributor candidate ID |
| dist_prio | input | 8 | Distributor candidate priority |
| loc_valid | input | 1 | Local candidate present |
| loc_id | input | 10 | Local candidate ID |
| loc_prio | input | 8 | Local candidate priority |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the read |
| irq_o | output | 1 | Interrupt request to the processor |
| dist_take | output | 1 | Distributor candidate claimed |
| loc_take | output | 1 | Local candidate claimed |
| take_id | output | 10 | ID claimed, valid with a take strobe |

## Verification
Arbitration between the two sources and the acknowledge claim happen in the same cycle. The bench provokes this by holding both candidates valid, with equal and with differing priorities, while it issues an acknowledge read. It judges the outcome by the returned ID, by which take strobe fired and by the running priority read afterwards, all compared with a bench model. Randomised rounds also combine a candidate change with acknowledges and completion writes in one cycle. The registered request line is checked against the model every cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_MASK = 3'd1,
    RA_ACK  = 3'd2,
    RA_EOI  = 3'd3,
    RA_RUN  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/pirq_select.sv
// Picks the more urgent of the distributor and local candidates.
module pirq_select #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input  logic              a_valid,
  input  logic [ID_W-1:0]   a_id,
  input  logic [PRIO_W-1:0] a_prio,
  input  logic              b_valid,
  input  logic [ID_W-1:0]   b_id,
  input  logic [PRIO_W-1:0] b_prio,
  output logic              win_valid,
  output logic [ID_W-1:0]   win_id,
  output logic [PRIO_W-1:0] win_prio,
  output logic              win_is_b
);
  always_comb begin
    win_is_b  = b_valid && (!a_valid || (b_prio <= a_prio));
    win_valid = a_valid || b_valid;
    win_id    = win_is_b ? b_id : a_id;
    win_prio  = win_is_b ? b_prio : a_prio;
  end
endmodule

// File: rtl/pirq_nest_stack.sv
// Holds claimed IDs with the running priority that preceded each claim.
module pirq_nest_stack #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [PRIO_W-1:0] run_prio,
  output logic [ID_W-1:0]   top_id,
  output logic              full,
  output logic              empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PRIO_W-1:0] run_q, run_d;
  logic [ID_W-1:0]   id_w   [DEPTH];
  logic [PRIO_W-1:0] prev_w [DEPTH];
  logic [IDX_W-1:0]  top_idx;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign top_id  = empty ? '0 : id_w[top_idx];
  assign run_prio = run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (push && !full) begin
      cnt_d = cnt_q + CNT_W'(1);
      run_d = push_prio;
    end else if (pop && !empty) begin
      cnt_d = cnt_q - CNT_W'(1);
      run_d = prev_w[top_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= IDLE_PRIO;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [ID_W-1:0]   id_r;
    logic [PRIO_W-1:0] prev_r;
    logic              wr_en;
    assign wr_en = push && (cnt_q == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_r   <= '0;
        prev_r <= IDLE_PRIO;
      end else if (wr_en) begin
        id_r   <= push_id;
        prev_r <= run_q;
      end
    end
    assign id_w[g]   = id_r;
    assign prev_w[g] = prev_r;
  end
endmodule

// File: rtl/pcpu_irq_if.sv
// Per-CPU interrupt interface: qualification, claim, completion.
module pcpu_irq_if
  import pirq_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dist_valid,
  input  logic [ID_W-1:0]   dist_id,
  input  logic [PRIO_W-1:0] dist_prio,
  input  logic              loc_valid,
  input  logic [ID_W-1:0]   loc_id,
  input  logic [PRIO_W-1:0] loc_prio,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              dist_take,
  output logic              loc_take,
  output logic [ID_W-1:0]   take_id
);
  localparam logic [ID_W-1:0] SPUR_ID = '1;

  // reset: asserted at once, released through two flops
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic              ctrl_en, ctrl_d, ctrl_we;
  logic [PRIO_W-1:0] mask_q, mask_d;
  logic              mask_we;
  logic              irq_q, irq_d;

  logic              win_valid, win_is_b;
  logic [ID_W-1:0]   win_id;
  logic [PRIO_W-1:0] win_prio;
  logic [PRIO_W-1:0] run_prio;
  logic [ID_W-1:0]   top_id;
  logic              stack_full, stack_empty;

  logic rd_cyc, wr_cyc, ack_rd, eoi_wr, qual, ack_fire, pop_ok;
  logic unused_wdata;

  pirq_select #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_sel (
    .a_valid  (dist_valid),
    .a_id     (dist_id),
    .a_prio   (dist_prio),
    .b_valid  (loc_valid),
    .b_id     (loc_id),
    .b_prio   (loc_prio),
    .win_valid(win_valid),
    .win_id   (win_id),
    .win_prio (win_prio),
    .win_is_b (win_is_b)
  );

  pirq_nest_stack #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (ack_fire),
    .push_id  (win_id),
    .push_prio(win_prio),
    .pop      (pop_ok),
    .run_prio (run_prio),
    .top_id   (top_id),
    .full     (stack_full),
    .empty    (stack_empty)
  );

  // decode and qualification
  always_comb begin
    rd_cyc   = bus_sel && !bus_wr;
    wr_cyc   = bus_sel && bus_wr;
    ack_rd   = rd_cyc && (bus_addr == RA_ACK);
    eoi_wr   = wr_cyc && (bus_addr == RA_EOI);
    qual     = ctrl_en && win_valid && (win_prio < mask_q) &&
               (win_prio < run_prio) && !stack_full;
    ack_fire = ack_rd && qual;
    pop_ok   = eoi_wr && !stack_empty && (bus_wdata[ID_W-1:0] == top_id);
    ctrl_we  = wr_cyc && (bus_addr == RA_CTRL);
    mask_we  = wr_cyc && (bus_addr == RA_MASK);
    ctrl_d   = bus_wdata[0];
    mask_d   = bus_wdata[PRIO_W-1:0];
    irq_d    = qual && !ack_fire;
  end

  assign unused_wdata = ^bus_wdata[DATA_W-1:ID_W];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_en <= 1'b0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_en <= ctrl_d;
      if (mask_we) mask_q  <= mask_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_cyc) begin
      case (bus_addr)
        RA_CTRL: bus_rdata = {{(DATA_W-1){1'b0}}, ctrl_en};
        RA_MASK: bus_rdata = {{(DATA_W-PRIO_W){1'b0}}, mask_q};
        RA_ACK:  bus_rdata = {{(DATA_W-ID_W){1'b0}}, (ack_fire ? win_id : SPUR_ID)};
        RA_RUN:  bus_rdata = {{(DATA_W-PRIO_W){1'b0}}, run_prio};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_o     = irq_q;
  assign dist_take = ack_fire && !win_is_b;
  assign loc_take  = ack_fire && win_is_b;
  assign take_id   = ack_fire ? win_id : '0;
endmodule

// File: rtl/pirq_if_chk.sv
module pirq_if_chk #(
  parameter int PRIO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              ctrl_en,
  input logic              dist_take,
  input logic              loc_take,
  input logic              ack_rd,
  input logic              eoi_wr,
  input logic              stack_full,
  input logic [PRIO_W-1:0] run_prio,
  input logic [PRIO_W-1:0] win_prio
);
  p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !irq_o);

  p_single_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dist_take && loc_take));

  p_take_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dist_take || loc_take) |-> ack_rd);

  p_claim_sets_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dist_take || loc_take) |=> (run_prio == $past(win_prio)));

  p_irq_drops_after_claim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dist_take || loc_take) |=> !irq_o);

  p_run_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_rd && !eoi_wr) |=> $stable(run_prio));

  p_full_blocks_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |-> !(dist_take || loc_take));
endmodule

bind pcpu_irq_if pirq_if_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .irq_o     (irq_o),
  .ctrl_en   (ctrl_en),
  .dist_take (dist_take),
  .loc_take  (loc_take),
  .ack_rd    (ack_rd),
  .eoi_wr    (eoi_wr),
  .stack_full(stack_full),
  .run_prio  (run_prio),
  .win_prio  (win_prio)
);

// File: tb/pcpu_irq_if_tb.sv
module pcpu_irq_if_tb_top;
  logic        clk;
  logic        rst_n;
  logic        dist_valid, loc_valid;
  logic [9:0]  dist_id, loc_id;
  logic [7:0]  dist_prio, loc_prio;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, dist_take, loc_take;
  logic [9:0]  take_id;

  int ntot, nbad;

  // bench model
  logic       m_en;
  logic [7:0] m_mask, m_run;
  int         m_cnt;
  logic [9:0] m_sid [8];
  logic [7:0] m_sprev [8];

  pcpu_irq_if dut_i (
    .clk(clk), .rst_n(rst_n),
    .dist_valid(dist_valid), .dist_id(dist_id), .dist_prio(dist_prio),
    .loc_valid(loc_valid), .loc_id(loc_id), .loc_prio(loc_prio),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .dist_take(dist_take), .loc_take(loc_take), .take_id(take_id)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic w_loc();
    return loc_valid && (!dist_valid || loc_prio <= dist_prio);
  endfunction

  function automatic logic m_qual();
    logic [7:0] p;
    p = w_loc() ? loc_prio : dist_prio;
    return m_en && (dist_valid || loc_valid) && (p < m_mask) && (p < m_run) && (m_cnt < 4);
  endfunction

  // one bus cycle, starting and ending at a falling edge
  task automatic cyc(input logic s, input logic w, input logic [2:0] a,
                     input logic [31:0] d, input string tag);
    logic        q, ackf, wl, exp_irq;
    logic [9:0]  wid;
    logic [7:0]  wp;
    logic [31:0] exp;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    wl   = w_loc();
    wid  = wl ? loc_id : dist_id;
    wp   = wl ? loc_prio : dist_prio;
    q    = m_qual();
    ackf = s && !w && (a == 3'd2) && q;
    if (s && !w) begin
      case (a)
        3'd0: exp = {31'd0, m_en};
        3'd1: exp = {24'd0, m_mask};
        3'd2: exp = {22'd0, (ackf ? wid : 10'd1023)};
        3'd4: exp = {24'd0, m_run};
        default: exp = 32'd0;
      endcase
      chk(bus_rdata == exp, tag, bus_rdata, exp);
    end else begin
      chk(bus_rdata == 32'd0, "R11", bus_rdata, 32'd0);
    end
    chk({dist_take, loc_take} == {ackf && !wl, ackf && wl}, "R5",
        {30'd0, dist_take, loc_take}, {30'd0, ackf && !wl, ackf && wl});
    if (ackf) chk(take_id == wid, "R6", {22'd0, take_id}, {22'd0, wid});
    exp_irq = q && !ackf;
    if (ackf) begin
      m_sid[m_cnt] = wid; m_sprev[m_cnt] = m_run; m_cnt++; m_run = wp;
    end
    if (s && w) begin
      if (a == 3'd0) m_en = d[0];
      if (a == 3'd1) m_mask = d[7:0];
      if (a == 3'd3 && m_cnt > 0 && d[9:0] == m_sid[m_cnt-1]) begin
        m_cnt--; m_run = m_sprev[m_cnt];
      end
    end
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk(irq_o == exp_irq, "R7", {31'd0, irq_o}, {31'd0, exp_irq});
  endtask

  task automatic set_dist(input logic v, input logic [9:0] i, input logic [7:0] p);
    dist_valid = v; dist_id = i; dist_prio = p;
  endtask
  task automatic set_loc(input logic v, input logic [9:0] i, input logic [7:0] p);
    loc_valid = v; loc_id = i; loc_prio = p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    ntot++; nbad++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    ntot = 0; nbad = 0;
    m_en = 1'b0; m_mask = 8'h00; m_run = 8'hFF; m_cnt = 0;
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 32'd0;
    set_dist(1'b0, 10'd0, 8'hFF);
    set_loc(1'b0, 10'd0, 8'hFF);
    void'($urandom(32'h1C0DE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(irq_o == 1'b0, "R1", {31'd0, irq_o}, 32'd0);
    cyc(1, 0, 3'd0, 0, "R1");
    cyc(1, 0, 3'd1, 0, "R1");
    cyc(1, 0, 3'd4, 0, "R1");
    cyc(1, 0, 3'd2, 0, "R1");

    // R2 disabled: candidate present, nothing signalled
    set_dist(1, 10'd40, 8'hA0);
    cyc(1, 1, 3'd1, 32'h0000_00F0, "R3");
    cyc(1, 0, 3'd2, 0, "R2");
    cyc(0, 0, 3'd0, 0, "R2");
    chk(irq_o == 1'b0, "R2", {31'd0, irq_o}, 32'd0);

    // R11 control keeps only bit 0
    cyc(1, 1, 3'd0, 32'hFFFF_FFFF, "R11");
    cyc(1, 0, 3'd0, 0, "R11");
    chk(irq_o == 1'b1, "R3", {31'd0, irq_o}, 32'd1);

    // R3 equal to mask is not signalled
    cyc(1, 1, 3'd1, 32'h0000_00A0, "R3");
    cyc(0, 0, 3'd0, 0, "R3");
    chk(irq_o == 1'b0, "R3", {31'd0, irq_o}, 32'd0);
    cyc(1, 1, 3'd1, 32'h0000_12F0, "R11");
    cyc(1, 0, 3'd1, 0, "R11");

    // R5 tie goes to the local source
    set_loc(1, 10'd5, 8'hA0);
    cyc(1, 0, 3'd2, 0, "R5");
    cyc(1, 0, 3'd4, 0, "R4");
    chk(irq_o == 1'b0, "R4", {31'd0, irq_o}, 32'd0);

    // R6 preemption by a more urgent distributor candidate
    set_loc(0, 10'd5, 8'hA0);
    set_dist(1, 10'd40, 8'h80);
    cyc(0, 0, 3'd0, 0, "R4");
    chk(irq_o == 1'b1, "R4", {31'd0, irq_o}, 32'd1);
    cyc(1, 0, 3'd2, 0, "R6");
    cyc(1, 0, 3'd4, 0, "R6");

    // R9 mismatched completion ignored, R8 matching pops
    cyc(1, 1, 3'd3, 32'd5, "R9");
    cyc(1, 0, 3'd4, 0, "R9");
    cyc(1, 1, 3'd3, 32'd40, "R8");
    cyc(1, 0, 3'd4, 0, "R8");
    cyc(1, 1, 3'd3, 32'd5, "R8");
    cyc(1, 0, 3'd4, 0, "R8");
    cyc(1, 1, 3'd3, 32'd5, "R9");
    cyc(1, 0, 3'd4, 0, "R9");

    // R10 fill the nesting stack
    for (int k = 0; k < 4; k++) begin
      set_dist(1, 10'(100 + k), 8'(8'h70 - 8'(16 * k)));
      cyc(1, 0, 3'd2, 0, "R10");
    end
    set_dist(1, 10'd200, 8'h10);
    cyc(0, 0, 3'd0, 0, "R10");
    chk(irq_o == 1'b0, "R10", {31'd0, irq_o}, 32'd0);
    cyc(1, 0, 3'd2, 0, "R10");
    for (int k = 3; k >= 0; k--) cyc(1, 1, 3'd3, 32'(100 + k), "R8");
    cyc(1, 0, 3'd4, 0, "R8");
    cyc(1, 0, 3'd6, 0, "R11");
    cyc(1, 0, 3'd5, 0, "R11");

    // randomised rounds
    for (int n = 0; n < 600; n++) begin
      int op;
      set_dist(($urandom % 4) != 0, 10'(32 + $urandom % 980), 8'($urandom % 256));
      set_loc(($urandom % 3) == 0, 10'($urandom % 32), 8'($urandom % 256));
      if (($urandom % 5) == 0) loc_prio = dist_prio;
      op = $urandom % 8;
      case (op)
        0, 1, 2: cyc(1, 0, 3'd2, 0, "R6");
        3, 4: cyc(1, 1, 3'd3,
                  (m_cnt > 0 && ($urandom % 4) != 0) ? {22'd0, m_sid[m_cnt-1]}
                                                     : 32'($urandom % 1024), "R8");
        5: cyc(1, 0, 3'd4, 0, "R4");
        6: cyc(1, 1, (($urandom % 8) == 0) ? 3'd0 : 3'd1,
               (($urandom % 8) == 0) ? 32'd1 : 32'(8'h80 + $urandom % 128), "R3");
        default: cyc(0, 0, 3'd0, 0, "R7");
      endcase
    end

    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule